// File: doc/BRIEF.md
# Expansion I/O Window Address Decoder

This block sits behind a cartridge-style expansion connector on a 16-bit-address, 8-bit-data bus with a phase clock (E) and a read/write strobe. It carves two otherwise redundant 16-byte I/O ranges, `$FF10-$FF1F` and `$FF30-$FF3F`, into eight peripheral slots of four bytes each. For each slot it drives one active-low chip select, gated by E. It also passes the two low address bits through as a register index, pulls an active-low override low so the host's own I/O decoding stands aside during the access, and steers a bidirectional data-bus buffer.

Slot numbering uses A5 as the top bit, followed by A3 and then A2. The lower 16-byte range therefore holds slots 0 to 3 and the upper range holds slots 4 to 7. Slot 1 carries a sample read-only eight-bit switch port. Because that port ignores A1 and A0, it shows up at all four byte addresses of its slot.

Every bus-facing output is a combinational function of the address, R/W and E. A registered copy of the most recent slot index, with a valid flag, gives observation one clock later.

Top module: `exio_decoder`

## Requirements
- R1: The window is hit exactly when addr[15:8] is 8'hFF, addr[7] and addr[6] are 0 and addr[4] is 1. This covers `$FF10-$FF1F` and `$FF30-$FF3F` and nothing else.
- R2: On a hit with E high, exactly one bit of sel_n is 0, and it is the bit at index {addr[5], addr[3], addr[2]}. Slot 0 starts at `$FF10` and slot 4 starts at `$FF30`.
- R3: reg_sel always equals addr[1:0].
- R4: While e_clk is 0, every bit of sel_n is 1.
- R5: host_ovr_n is 0 exactly when the window is hit, whatever the level of E.
- R6: buf_to_cpu equals rw, where rw=1 means a read and buf_to_cpu=1 drives data toward the processor.
- R7: buf_en_n is 0 only while e_clk is 1 and the window is hit.
- R8: During a read with E high at any of `$FF14`, `$FF15`, `$FF16` or `$FF17`, sw_drive is 1 and sw_data equals sw_in. At all other times sw_drive is 0 and sw_data is 8'h00.
- R9: A write (rw=0) to `$FF14-$FF17` leaves sw_drive at 0 and sw_data at 8'h00.
- R10: Addresses outside the window, including `$FF00-$FF0F`, `$FF20-$FF2F` and `$FF40-$FF5F`, give sel_n = 8'hFF and host_ovr_n = 1.
- R11: At each rising clk edge out of reset, slot_q takes {addr[5],addr[3],addr[2]} and slot_vld takes the hit flag. A synchronous active-high rst clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the observation register |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Processor address bus |
| rw | input | 1 | 1 = read, 0 = write |
| e_clk | input | 1 | Processor E phase clock |
| sw_in | input | 8 | Switch bank levels |
| sel_n | output | 8 | Active-low device selects, one per slot |
| reg_sel | output | 2 | Register index passed to the device |
| host_ovr_n | output | 1 | Active-low override of host internal I/O selects |
| buf_to_cpu | output | 1 | Data buffer direction, 1 = toward processor |
| buf_en_n | output | 1 | Active-low data buffer enable |
| sw_drive | output | 1 | Switch port is driving read data |
| sw_data | output | 8 | Switch port read data |
| slot_q | output | 3 | Registered slot index |
| slot_vld | output | 1 | Registered window-hit flag |

## Verification
The assertions check, on every clock, the properties that hold without reference to the address: no select while E is low, at most one select active, an enabled buffer or an active select only under the override, the switch port driving only on a read of its own slot, and the valid flag tracking the previous hit. Whether the decode picks the right slot for each address, that the switch value appears at all four echo addresses, and that the neighbouring `$FF00`, `$FF20` and `$FF40` pages stay silent can only be shown by the bench's directed address sweeps, which compare against a model.

// File: rtl/exio_pkg.sv
package exio_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int SLOT_BITS = 3;
    localparam int NUM_SLOTS = 1 << SLOT_BITS;
    localparam int REG_BITS  = 2;
    localparam logic [7:0] IO_PAGE = 8'hFF;
    localparam int SW_SLOT   = 1;

    typedef logic [SLOT_BITS-1:0] slot_idx_t;

    typedef struct packed {
        logic                hit;
        slot_idx_t           slot;
        logic [REG_BITS-1:0] reg_sel;
    } decode_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return (a[15:8] == IO_PAGE) && (a[7:6] == 2'b00) && a[4];
    endfunction

    function automatic slot_idx_t slot_of(input logic [ADDR_W-1:0] a);
        return {a[5], a[3], a[2]};
    endfunction
endpackage

// File: rtl/exio_window_match.sv
module exio_window_match
    import exio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    always_comb begin
        dec.hit     = in_window(addr);
        dec.slot    = slot_of(addr);
        dec.reg_sel = addr[REG_BITS-1:0];
    end
endmodule

// File: rtl/exio_slot_select.sv
module exio_slot_select
    import exio_pkg::*;
(
    input  logic                 hit,
    input  logic                 e_clk,
    input  slot_idx_t            slot,
    output logic [NUM_SLOTS-1:0] sel_n
);
    logic qualified;
    assign qualified = hit & e_clk;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_sel
        assign sel_n[i] = ~(qualified && (slot == slot_idx_t'(i)));
    end
endmodule

// File: rtl/exio_bus_ctl.sv
module exio_bus_ctl (
    input  logic hit,
    input  logic e_clk,
    input  logic rw,
    output logic host_ovr_n,
    output logic buf_to_cpu,
    output logic buf_en_n
);
    assign host_ovr_n = ~hit;
    assign buf_to_cpu = rw;
    assign buf_en_n   = ~(hit & e_clk);
endmodule

// File: rtl/exio_switch_port.sv
module exio_switch_port
    import exio_pkg::*;
(
    input  logic              cs_n,
    input  logic              rw,
    input  logic [DATA_W-1:0] sw_in,
    output logic              drive,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        drive = ~cs_n & rw;
        data  = drive ? sw_in : '0;
    end
endmodule

// File: rtl/exio_decoder.sv
module exio_decoder
    import exio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  rw,
    input  logic                  e_clk,
    input  logic [DATA_W-1:0]     sw_in,
    output logic [NUM_SLOTS-1:0]  sel_n,
    output logic [REG_BITS-1:0]   reg_sel,
    output logic                  host_ovr_n,
    output logic                  buf_to_cpu,
    output logic                  buf_en_n,
    output logic                  sw_drive,
    output logic [DATA_W-1:0]     sw_data,
    output logic [SLOT_BITS-1:0]  slot_q,
    output logic                  slot_vld
);
    decode_t dec;

    exio_window_match u_match (.addr(addr), .dec(dec));

    exio_slot_select u_sel (
        .hit(dec.hit), .e_clk(e_clk), .slot(dec.slot), .sel_n(sel_n)
    );

    exio_bus_ctl u_bus (
        .hit(dec.hit), .e_clk(e_clk), .rw(rw),
        .host_ovr_n(host_ovr_n), .buf_to_cpu(buf_to_cpu), .buf_en_n(buf_en_n)
    );

    exio_switch_port u_sw (
        .cs_n(sel_n[SW_SLOT]), .rw(rw), .sw_in(sw_in),
        .drive(sw_drive), .data(sw_data)
    );

    assign reg_sel = dec.reg_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            slot_vld <= 1'b0;
        end else begin
            slot_q   <= dec.slot;
            slot_vld <= dec.hit;
        end
    end

    // R4: selects idle while E is low
    a_r4_no_sel_e_low: assert property (@(posedge clk) disable iff (rst)
        !e_clk |-> (sel_n == {NUM_SLOTS{1'b1}}));

    // R2: never more than one select
    a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
        $countones(~sel_n) <= 1);

    // R7 with R5: buffer enabled only under host override
    a_r7_en_under_ovr: assert property (@(posedge clk) disable iff (rst)
        !buf_en_n |-> !host_ovr_n);

    // R10: any active select implies override
    a_r10_sel_needs_ovr: assert property (@(posedge clk) disable iff (rst)
        (sel_n != {NUM_SLOTS{1'b1}}) |-> (!host_ovr_n && !buf_en_n));

    // R8 / R9: switch drives only on a read of its own slot
    a_r8_sw_read_only: assert property (@(posedge clk) disable iff (rst)
        sw_drive |-> (rw && !sel_n[SW_SLOT]));

    // R11: registered flag tracks previous override
    a_r11_vld_tracks: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (slot_vld == $past(!host_ovr_n)));
endmodule

// File: tb/tb_exio_decoder.sv
module tb_exio_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        rw;
    logic        e_clk;
    logic [7:0]  sw_in;
    logic [7:0]  sel_n;
    logic [1:0]  reg_sel;
    logic        host_ovr_n, buf_to_cpu, buf_en_n, sw_drive, slot_vld;
    logic [7:0]  sw_data;
    logic [2:0]  slot_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    exio_decoder dut (
        .clk(clk), .rst(rst), .addr(addr), .rw(rw), .e_clk(e_clk), .sw_in(sw_in),
        .sel_n(sel_n), .reg_sel(reg_sel), .host_ovr_n(host_ovr_n),
        .buf_to_cpu(buf_to_cpu), .buf_en_n(buf_en_n), .sw_drive(sw_drive),
        .sw_data(sw_data), .slot_q(slot_q), .slot_vld(slot_vld)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [15:0] a);
        return a >= 16'hFF10 && a <= 16'hFF1F || a >= 16'hFF30 && a <= 16'hFF3F;
    endfunction

    function automatic logic [2:0] m_slot(input logic [15:0] a);
        return 3'((a - (a >= 16'hFF30 ? 16'hFF30 : 16'hFF10)) >> 2)
               + (a >= 16'hFF30 ? 3'd4 : 3'd0);
    endfunction

    task automatic apply(input logic [15:0] a, input logic r, input logic e);
        @(negedge clk);
        addr = a; rw = r; e_clk = e;
        #1;
    endtask

    task automatic check_full(input logic [15:0] a, input logic r, input logic e);
        bit h;
        logic [7:0] exp_sel;
        bit swr;
        apply(a, r, e);
        h = m_hit(a);
        exp_sel = 8'hFF;
        if (h && e) exp_sel[m_slot(a)] = 1'b0;
        chk(h ? "R2" : "R10", $sformatf("sel_n @%h e=%0b", a, e), sel_n, exp_sel);
        chk(h ? "R5" : "R10", $sformatf("host_ovr_n @%h", a), host_ovr_n, !h);
        chk("R3", $sformatf("reg_sel @%h", a), reg_sel, a[1:0]);
        chk("R6", $sformatf("buf_to_cpu @%h", a), buf_to_cpu, r);
        chk("R7", $sformatf("buf_en_n @%h", a), buf_en_n, !(h && e));
        swr = (a >= 16'hFF14 && a <= 16'hFF17) && r && e;
        chk(r ? "R8" : "R9", $sformatf("sw_drive @%h", a), sw_drive, swr);
        chk(r ? "R8" : "R9", $sformatf("sw_data @%h", a), sw_data, swr ? sw_in : 8'h00);
    endtask

    task automatic t_reset;
        rst = 1'b1; addr = 16'hFF10; rw = 1'b1; e_clk = 1'b1; sw_in = 8'hA5;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "slot_q in reset", slot_q, 0);
        chk("R11", "slot_vld in reset", slot_vld, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_slot_bases;   // R1 R2
        apply(16'hFF10, 1'b1, 1'b1);
        chk("R2", "slot0 base", sel_n, 8'hFE);
        apply(16'hFF30, 1'b1, 1'b1);
        chk("R2", "slot4 base", sel_n, 8'hEF);
        apply(16'hFF3F, 1'b0, 1'b1);
        chk("R1", "top of upper range", sel_n, 8'h7F);
    endtask

    task automatic t_sweep_window;   // R1 R2 R3 R5 R6 R7
        for (int a = 16'hFF00; a <= 16'hFF5F; a++) begin
            check_full(16'(a), 1'b1, 1'b1);
        end
    endtask

    task automatic t_e_low;   // R4 R5 R7
        for (int a = 16'hFF10; a <= 16'hFF3F; a += 3) begin
            check_full(16'(a), 1'b1, 1'b0);
            chk("R4", "no select with E low", sel_n, 8'hFF);
        end
    endtask

    task automatic t_outside;   // R10
        logic [15:0] far [4] = '{16'h0000, 16'h7F14, 16'hFE14, 16'hFF94};
        foreach (far[i]) check_full(far[i], 1'b1, 1'b1);
        check_full(16'hFF04, 1'b0, 1'b1);
        check_full(16'hFF24, 1'b1, 1'b1);
        check_full(16'hFF44, 1'b1, 1'b1);
    endtask

    task automatic t_switch_echo;   // R8
        logic [7:0] pats [3] = '{8'h00, 8'h5A, 8'hFF};
        foreach (pats[p]) begin
            sw_in = pats[p];
            for (int a = 16'hFF14; a <= 16'hFF17; a++) begin
                apply(16'(a), 1'b1, 1'b1);
                chk("R8", $sformatf("switch echo @%h", a), sw_data, pats[p]);
                chk("R8", "switch drive", sw_drive, 1);
            end
        end
        apply(16'hFF18, 1'b1, 1'b1);
        chk("R8", "slot2 not switch", sw_drive, 0);
    endtask

    task automatic t_switch_write;   // R9
        sw_in = 8'hC3;
        for (int a = 16'hFF14; a <= 16'hFF17; a++) begin
            check_full(16'(a), 1'b0, 1'b1);
            chk("R9", "write ignored drive", sw_drive, 0);
            chk("R9", "write ignored data", sw_data, 8'h00);
        end
        apply(16'hFF14, 1'b1, 1'b1);
        chk("R9", "read after write unchanged", sw_data, 8'hC3);
    endtask

    task automatic t_registered;   // R11
        logic [15:0] seq [4] = '{16'hFF2C, 16'hFF08, 16'hFF34, 16'hFF1C};
        foreach (seq[i]) begin
            apply(seq[i], 1'b1, 1'b0);
            @(posedge clk); #1;
            chk("R11", $sformatf("slot_vld after %h", seq[i]), slot_vld, m_hit(seq[i]));
            chk("R11", $sformatf("slot_q after %h", seq[i]), slot_q,
                {seq[i][5], seq[i][3], seq[i][2]});
        end
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R11", "reset clears slot_q", slot_q, 0);
        chk("R11", "reset clears slot_vld", slot_vld, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_slot_bases();
        t_sweep_window();
        t_e_low();
        t_outside();
        t_switch_echo();
        t_switch_write();
        t_registered();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule